// File: doc/BRIEF.md
# Pipelined Carry-Save Array Multiplier

This block multiplies two unsigned 8-bit operands and returns a 16-bit product. It accepts a new operand pair on every clock. Each multiplier bit gates a copy of the multiplicand, and that copy is shifted left by the bit's position. The rows formed this way are reduced by successive layers of 3:2 carry-save adders. Registers split these layers into a fixed number of stages, so the block works on several operand pairs at once, each in a different stage.

When only two rows are left, a carry-propagate adder resolves them and the result is registered at the output. A valid flag moves in step with the data through every stage. An upstream unit can therefore stream operand pairs back to back and read one finished product per clock, after a fixed four-clock fill. The operand width, the number of registered reduction stages and the final adder's structure (ripple or parallel-prefix) are parameters. Reset is synchronous and active high. It clears the valid flags only.

Top module: `csa_mult_pipe`

## Requirements
- R1: When `out_valid` is high, `out_p` equals the unsigned product `in_a * in_b` of the pair that was accepted with that result.
- R2: A pair presented with `in_valid` high in clock cycle c produces `out_valid` high, with its product, in cycle c+4. Before that cycle no result for it appears.
- R3: Pairs presented in consecutive cycles come out in consecutive cycles, one per clock. For m back-to-back pairs, the last product appears m+3 cycles after the first pair is captured (n+m-1 with n = 4 stages).
- R4: `out_valid` copies the `in_valid` pattern four cycles later. Gaps in the input stream appear as gaps in the output stream, and no extra valid cycles are created.
- R5: `rst` is synchronous and active high. While it is sampled high, operand pairs are not accepted. It also discards every pair already in flight, so `out_valid` is low in the cycle after any clock edge that samples `rst` high. Pairs presented after release are processed normally.
- R6: Corner operands give exact results: any operand equal to 0 gives a product of 0, and 255 * 255 gives 65025 (0xFE01).
- R7: A multiplier with only bit i set (value 1<<i, i = 0..7) returns the multiplicand shifted left by i. The same holds with the operand roles swapped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset; clears all valid flags |
| in_valid | input | 1 | Qualifies the operand pair in this cycle |
| in_a | input | 8 | Multiplicand, unsigned |
| in_b | input | 8 | Multiplier, unsigned |
| out_valid | output | 1 | Qualifies `out_p` |
| out_p | output | 16 | Unsigned product |

## Verification
Two things can fall on the same clock edge: the synchronous reset, and the acceptance of a fresh operand pair while older pairs fill every stage. The bench streams valid pairs and raises reset on a cycle where `in_valid` is also high. It then releases reset and at once presents new pairs. The bench judges the outcome cycle by cycle. The pair presented with reset, and the three pairs behind the output, must never show up. The first pair after release must emerge exactly four cycles later with its correct product.

// File: rtl/csa_mult_pkg.sv
`timescale 1ns/1ps
package csa_mult_pkg;

   typedef enum logic {
      CPA_RIPPLE = 1'b0,
      CPA_PREFIX = 1'b1
   } cpa_kind_e;

   // rows left after one layer of 3:2 compressors
   function automatic int rows_after(input int n);
      return 2 * (n / 3) + (n % 3);
   endfunction

   // rows present at the input of reduction level lvl
   function automatic int rows_at(input int n0, input int lvl);
      int r;
      r = n0;
      for (int i = 0; i < lvl; i++) r = rows_after(r);
      return r;
   endfunction

   // number of 3:2 levels needed to bring n0 rows down to two
   function automatic int csa_levels(input int n0);
      int r;
      int c;
      r = n0;
      c = 0;
      while (r > 2) begin
         r = rows_after(r);
         c++;
      end
      return c;
   endfunction

   // pipeline stage that owns reduction level lvl
   function automatic int stage_of(input int lvl, input int stages, input int levels);
      return (lvl * stages) / levels;
   endfunction

endpackage

// File: rtl/csa_mult_ppgen.sv
`timescale 1ns/1ps
module csa_mult_ppgen #(
   parameter int OP_W = 8
) (
   input  logic [OP_W-1:0]   mcand,
   input  logic [OP_W-1:0]   mplier,
   output logic [2*OP_W-1:0] pp [OP_W]
);
   localparam int PW = 2 * OP_W;

   if (PW != 2 * OP_W) begin : g_bad_pw
      $error("csa_mult_ppgen: row width mismatch");
   end

   for (genvar i = 0; i < OP_W; i++) begin : g_row
      assign pp[i] = {{OP_W{1'b0}}, mcand & {OP_W{mplier[i]}}} << i;
   end

endmodule

// File: rtl/csa_mult_layer.sv
`timescale 1ns/1ps
module csa_mult_layer #(
   parameter int PW    = 16,
   parameter int N_IN  = 8,
   parameter int N_OUT = 6
) (
   input  logic [PW-1:0] rows_i [N_IN],
   output logic [PW-1:0] rows_o [N_OUT]
);
   localparam int NGRP  = N_IN / 3;
   localparam int NPASS = N_IN % 3;

   if (N_OUT != 2 * NGRP + NPASS) begin : g_bad_rows
      $error("csa_mult_layer: N_OUT does not match N_IN");
   end
   if (PW < 2) begin : g_bad_w
      $error("csa_mult_layer: PW must be at least 2");
   end

   for (genvar g = 0; g < NGRP; g++) begin : g_grp
      logic [PW-2:0] ma, mb, mc;
      assign ma = rows_i[3*g][PW-2:0];
      assign mb = rows_i[3*g+1][PW-2:0];
      assign mc = rows_i[3*g+2][PW-2:0];
      // sum row: bitwise three-input parity
      assign rows_o[2*g]   = rows_i[3*g] ^ rows_i[3*g+1] ^ rows_i[3*g+2];
      // carry row: majority moved up one weight; the top carry leaves the modulus
      assign rows_o[2*g+1] = {(ma & mb) | (ma & mc) | (mb & mc), 1'b0};
   end

   for (genvar p = 0; p < NPASS; p++) begin : g_pass
      assign rows_o[2*NGRP+p] = rows_i[3*NGRP+p];
   end

endmodule

// File: rtl/csa_mult_cpa.sv
`timescale 1ns/1ps
module csa_mult_cpa
   import csa_mult_pkg::*;
#(
   parameter int        PW   = 16,
   parameter cpa_kind_e KIND = CPA_PREFIX
) (
   input  logic [PW-1:0] a,
   input  logic [PW-1:0] b,
   output logic [PW-1:0] sum
);
   localparam int NB = PW - 1;
   localparam int LG = (NB > 1) ? $clog2(NB) : 1;

   if (PW < 3) begin : g_bad_w
      $error("csa_mult_cpa: PW must be at least 3");
   end

   if (KIND == CPA_RIPPLE) begin : g_ripple
      logic [PW-1:0] cy;
      always_comb begin
         cy[0] = 1'b0;
         for (int i = 0; i < PW - 1; i++) begin
            cy[i+1] = (a[i] & b[i]) | (cy[i] & (a[i] ^ b[i]));
         end
         sum = a ^ b ^ cy;
      end
   end else begin : g_prefix
      logic [NB-1:0] gv, pv, gn, pn;
      always_comb begin
         int d;
         gv = a[NB-1:0] & b[NB-1:0];
         pv = a[NB-1:0] ^ b[NB-1:0];
         for (int s = 0; s < LG; s++) begin
            d  = 1 << s;
            gn = gv;
            pn = pv;
            for (int i = d; i < NB; i++) begin
               gn[i] = gv[i] | (pv[i] & gv[i-d]);
               pn[i] = pv[i] & pv[i-d];
            end
            gv = gn;
            pv = pn;
         end
         // gv[i] is now the carry out of bits [i:0]
         sum = a ^ b ^ {gv, 1'b0};
      end
   end

endmodule

// File: rtl/csa_mult_pipe.sv
`timescale 1ns/1ps
module csa_mult_pipe
   import csa_mult_pkg::*;
#(
   parameter int        OP_W       = 8,
   parameter int        CSA_STAGES = 3,
   parameter cpa_kind_e CPA_KIND   = CPA_PREFIX
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              in_valid,
   input  logic [OP_W-1:0]   in_a,
   input  logic [OP_W-1:0]   in_b,
   output logic              out_valid,
   output logic [2*OP_W-1:0] out_p
);
   localparam int PW   = 2 * OP_W;
   localparam int NLVL = csa_levels(OP_W);
   localparam int LAT  = CSA_STAGES + 1;

   if (OP_W < 3) begin : g_bad_opw
      $error("csa_mult_pipe: OP_W must be at least 3");
   end
   if (CSA_STAGES < 1 || CSA_STAGES > NLVL) begin : g_bad_stages
      $error("csa_mult_pipe: CSA_STAGES must lie between 1 and the number of 3:2 levels");
   end

   // partial-product rows
   logic [PW-1:0] pp_rows [OP_W];

   csa_mult_ppgen #(.OP_W(OP_W)) u_ppgen (
      .mcand  (in_a),
      .mplier (in_b),
      .pp     (pp_rows)
   );

   // reduction levels, with a register cut after the last level of each stage
   for (genvar l = 0; l < NLVL; l++) begin : g_lvl
      localparam int NI = rows_at(OP_W, l);
      localparam int NO = rows_at(OP_W, l + 1);
      localparam bit CUT = (l == NLVL - 1) ||
                           (stage_of(l + 1, CSA_STAGES, NLVL) != stage_of(l, CSA_STAGES, NLVL));

      logic [PW-1:0] rows_i [NI];
      logic [PW-1:0] rows_c [NO];
      logic [PW-1:0] rows_o [NO];

      if (l == 0) begin : g_src_pp
         assign rows_i = pp_rows;
      end else begin : g_src_prev
         assign rows_i = g_lvl[l-1].rows_o;
      end

      csa_mult_layer #(.PW(PW), .N_IN(NI), .N_OUT(NO)) u_layer (
         .rows_i (rows_i),
         .rows_o (rows_c)
      );

      if (CUT) begin : g_reg
         always_ff @(posedge clk) begin
            rows_o <= rows_c;
         end
      end else begin : g_wire
         assign rows_o = rows_c;
      end
   end

   // final carry-propagate adder and output register
   logic [PW-1:0] cpa_sum;

   csa_mult_cpa #(.PW(PW), .KIND(CPA_KIND)) u_cpa (
      .a   (g_lvl[NLVL-1].rows_o[0]),
      .b   (g_lvl[NLVL-1].rows_o[1]),
      .sum (cpa_sum)
   );

   always_ff @(posedge clk) begin
      out_p <= cpa_sum;
   end

   // valid flags travel beside the data, one per register cut
   logic [LAT-1:0] vld_q;

   always_ff @(posedge clk) begin
      if (rst) vld_q <= '0;
      else     vld_q <= {vld_q[LAT-2:0], in_valid};
   end

   assign out_valid = vld_q[LAT-1];

endmodule

// File: rtl/csa_mult_chk.sv
`timescale 1ns/1ps
module csa_mult_chk #(
   parameter int OP_W = 8,
   parameter int LAT  = 4
) (
   input logic              clk,
   input logic              rst,
   input logic              in_valid,
   input logic [OP_W-1:0]   in_a,
   input logic [OP_W-1:0]   in_b,
   input logic              out_valid,
   input logic [2*OP_W-1:0] out_p
);
   localparam int PW = 2 * OP_W;

   logic [LAT-1:0] vq;
   logic [LAT-1:0] zq;
   logic [PW-1:0]  pq [LAT];

   always_ff @(posedge clk) begin
      if (rst) vq <= '0;
      else     vq <= {vq[LAT-2:0], in_valid};
   end

   always_ff @(posedge clk) begin
      zq    <= {zq[LAT-2:0], (in_a == '0) || (in_b == '0)};
      pq[0] <= PW'(in_a) * PW'(in_b);
      for (int i = 1; i < LAT; i++) pq[i] <= pq[i-1];
   end

   AST_PRODUCT_MATCH: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> (out_p == pq[LAT-1])); // R1

   AST_PRODUCT_KNOWN: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> !$isunknown(out_p)); // R1

   AST_VALID_DELAY: assert property (@(posedge clk) disable iff (rst)
      out_valid == vq[LAT-1]); // R2

   AST_RESET_FLUSH: assert property (@(posedge clk)
      rst |=> !out_valid); // R5

   AST_ZERO_OPERAND: assert property (@(posedge clk) disable iff (rst)
      (out_valid && zq[LAT-1]) |-> (out_p == '0)); // R6

endmodule

bind csa_mult_pipe csa_mult_chk #(.OP_W(OP_W), .LAT(LAT)) u_chk (
   .clk       (clk),
   .rst       (rst),
   .in_valid  (in_valid),
   .in_a      (in_a),
   .in_b      (in_b),
   .out_valid (out_valid),
   .out_p     (out_p)
);

// File: tb/csa_mult_pipe_test.sv
`timescale 1ns/1ps
module csa_mult_pipe_test;

   logic        clk = 1'b0;
   logic        rst;
   logic        in_valid;
   logic [7:0]  in_a, in_b;
   logic        out_valid;
   logic [15:0] out_p;

   int    n_tests = 0;
   int    n_fail  = 0;
   int    step_n  = 0;
   int    seen_cnt = 0;
   int    last_seen = -1;
   string cur_req = "R5";

   logic       hv [16];
   logic [7:0] ha [16];
   logic [7:0] hb [16];

   always #4 clk = ~clk;

   csa_mult_pipe uut (
      .clk       (clk),
      .rst       (rst),
      .in_valid  (in_valid),
      .in_a      (in_a),
      .in_b      (in_b),
      .out_valid (out_valid),
      .out_p     (out_p)
   );

   // compare the port values at this falling edge with the pair driven four steps earlier
   task automatic check_out();
      int          k;
      logic        ev;
      logic [15:0] ep;
      k  = (step_n - 4) & 15;
      ev = (step_n >= 4) ? hv[k] : 1'b0;
      ep = 16'(ha[k]) * 16'(hb[k]);
      n_tests++;
      if (ev) begin
         if (out_valid !== 1'b1 || out_p !== ep) begin
            n_fail++;
            $display("FAIL %s step %0d: valid=%b p=%0d, expected valid=1 p=%0d",
                     cur_req, step_n, out_valid, out_p, ep);
         end
      end else if (out_valid !== 1'b0) begin
         n_fail++;
         $display("FAIL %s step %0d: valid=%b, expected valid=0", cur_req, step_n, out_valid);
      end
      if (out_valid === 1'b1) begin
         seen_cnt++;
         last_seen = step_n;
      end
   endtask

   task automatic step(input logic v, input logic [7:0] a, input logic [7:0] b, input logic r);
      int k;
      @(negedge clk);
      check_out();
      rst      = r;
      in_valid = v;
      in_a     = a;
      in_b     = b;
      k        = step_n & 15;
      hv[k]    = v && !r;
      ha[k]    = a;
      hb[k]    = b;
      if (r) begin
         for (int j = 1; j <= 3; j++) hv[(step_n - j) & 15] = 1'b0;
      end
      step_n++;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) step(1'b0, 8'h00, 8'h00, 1'b0);
   endtask

   task automatic t_reset();
      cur_req = "R5";
      for (int i = 0; i < 4; i++) step(1'b1, 8'($urandom), 8'($urandom), 1'b1);
      idle(5);
   endtask

   task automatic t_latency();
      cur_req = "R2";
      step(1'b1, 8'd13, 8'd11, 1'b0);
      idle(6);
   endtask

   task automatic t_corners();
      cur_req = "R6";
      step(1'b1, 8'd0,   8'd0,   1'b0);
      step(1'b1, 8'd0,   8'd255, 1'b0);
      step(1'b1, 8'd255, 8'd0,   1'b0);
      step(1'b1, 8'd255, 8'd255, 1'b0);
      step(1'b1, 8'd1,   8'd255, 1'b0);
      step(1'b1, 8'd255, 8'd1,   1'b0);
      idle(5);
   endtask

   task automatic t_bits();
      cur_req = "R7";
      for (int i = 0; i < 8; i++) step(1'b1, 8'hB5, 8'(1 << i), 1'b0);
      for (int i = 0; i < 8; i++) step(1'b1, 8'(1 << i), 8'hFF, 1'b0);
      idle(5);
   endtask

   task automatic t_stream();
      int m;
      int first;
      m       = 40;
      cur_req = "R1";
      seen_cnt  = 0;
      last_seen = -1;
      first   = step_n;
      for (int i = 0; i < m; i++) step(1'b1, 8'($urandom), 8'($urandom), 1'b0);
      idle(5);
      n_tests++;
      if (seen_cnt != m || (last_seen - first) != m + 3) begin
         n_fail++;
         $display("FAIL R3 throughput: results=%0d span=%0d, expected results=%0d span=%0d",
                  seen_cnt, last_seen - first, m, m + 3);
      end
   endtask

   task automatic t_gaps();
      logic [9:0] pat;
      pat     = 10'b1011011001;
      cur_req = "R4";
      for (int i = 0; i < 10; i++) step(pat[i], 8'($urandom), 8'($urandom), 1'b0);
      idle(5);
   endtask

   task automatic t_reset_flight();
      cur_req = "R5";
      for (int i = 0; i < 5; i++) step(1'b1, 8'($urandom), 8'($urandom), 1'b0);
      step(1'b1, 8'd200, 8'd200, 1'b1);
      for (int i = 0; i < 4; i++) step(1'b1, 8'($urandom), 8'($urandom), 1'b0);
      idle(5);
   endtask

   initial begin
      rst      = 1'b1;
      in_valid = 1'b0;
      in_a     = '0;
      in_b     = '0;
      for (int i = 0; i < 16; i++) begin
         hv[i] = 1'b0;
         ha[i] = '0;
         hb[i] = '0;
      end
      t_reset();
      t_latency();
      t_corners();
      t_bits();
      t_stream();
      t_gaps();
      t_reset_flight();
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      #(8 * 20000);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule